// File: doc/BRIEF.md
# Modem Status Change Detector

This block keeps the modem status register of a serial port. It watches four handshake inputs from a modem: clear to send (CTS), data set ready (DSR), ring indicator (RI) and carrier detect (DCD). It shows their current levels and keeps a sticky change flag for each. A modem-status interrupt is raised whenever any change flag is set and the interrupt enable allows it. The CPU reaches the block through a small register port with select, read and write strobes and a two-bit address. The block holds an interrupt enable register, a modem control register and the status register.

Setting the loopback bit of the modem control register puts the block in a diagnostic mode. The external inputs are then ignored, and the four status sources are taken from the low bits of the modem control register. Change flags and the interrupt keep working as in normal operation. This lets software raise and clear modem interrupts without any cable attached.

Register addresses: 0 selects the interrupt enable register, 1 the modem control register, 2 the modem status register, and 3 reads as zero.

Top module: `modem_status_ctl`

## Requirements
- R1: After reset, all three registers read 0x00 and `irq` is low.
- R2: The status register holds the current levels in bits 4 to 7: CTS in bit 4, DSR in bit 5, RI in bit 6 and DCD in bit 7. A change on an external input shows there on the third rising edge after it, because of two synchroniser stages and one capture stage.
- R3: Bits 0, 1 and 3 are the change flags for CTS, DSR and DCD. Each one is set by any change of level in its source. It then stays set, through further changes, until the status register is read.
- R4: A read of address 2 clears all change flags at the edge that ends the read. If a source changes in that same cycle, its flag is set again and is not lost.
- R5: Bit 2 is the ring flag. It is set only when RI goes from 1 to 0. A 0-to-1 change of RI leaves it untouched.
- R6: Modem control bit 4 selects loopback. In loopback mode the sources are taken from the control register: bit 1 drives CTS, bit 0 drives DSR, bit 2 drives RI and bit 3 drives DCD. The external inputs have no effect while loopback is set. `loop_active` shows the state of bit 4.
- R7: Modem control bits 7 to 5 always read 0. Only bits 3 to 0 of the interrupt enable register are kept, and its bits 7 to 4 read 0.
- R8: `irq` is high exactly when interrupt enable bit 3 is 1 and at least one change flag is set. This also holds in loopback mode.
- R9: Writing 0 to modem control bit 4 returns the sources to the synchronised external inputs. Any difference from the last captured levels then sets the change flags as in R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of address 2 clears the flags |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cts_in | input | 1 | Clear to send from the modem (asynchronous) |
| dsr_in | input | 1 | Data set ready from the modem (asynchronous) |
| ri_in | input | 1 | Ring indicator from the modem (asynchronous) |
| dcd_in | input | 1 | Carrier detect from the modem (asynchronous) |
| loop_active | output | 1 | Loopback mode is active |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that the CPU strobes are single-cycle pulses, held stable across the edge that samples them. They also assume that the control register changes only through bus writes. The loopback property relies on the source vector being purely a function of registered state while loopback holds. The stimulus changes strobes and modem inputs only at falling edges. Each status read is timed from the known synchroniser latency, so that one case puts a source change on exactly the edge of a clearing read.

// File: rtl/modem_status_ctl.sv
module modem_status_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int MSI_EN_BIT  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       ri_in,
  input  logic       dcd_in,
  output logic       loop_active,
  output logic       irq
);
  localparam logic [1:0] A_IER = 2'd0;
  localparam logic [1:0] A_MCR = 2'd1;
  localparam logic [1:0] A_MSR = 2'd2;
  localparam int LAST = SYNC_STAGES - 1;

  logic [3:0] ier_q;
  logic [4:0] mcr_q;
  logic [3:0] state_q, delta_q, src, edge_vec;
  logic [3:0] sync_q [SYNC_STAGES];
  logic       wr_ier, wr_mcr, rd_msr;
  logic       unused_wdata;

  assign unused_wdata = ^bus_wdata[7:5];
  assign wr_ier = bus_sel & bus_wr & (bus_addr == A_IER);
  assign wr_mcr = bus_sel & bus_wr & (bus_addr == A_MCR);
  assign rd_msr = bus_sel & bus_rd & (bus_addr == A_MSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {dcd_in, ri_in, dsr_in, cts_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign loop_active = mcr_q[4];
  assign src = loop_active ? {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]} : sync_q[LAST];
  assign edge_vec = {src[3] ^ state_q[3], state_q[2] & ~src[2],
                     src[1] ^ state_q[1], src[0] ^ state_q[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q   <= '0;
      mcr_q   <= '0;
      state_q <= '0;
      delta_q <= '0;
    end else begin
      if (wr_ier) ier_q <= bus_wdata[3:0];
      if (wr_mcr) mcr_q <= bus_wdata[4:0];
      state_q <= src;
      delta_q <= (rd_msr ? 4'b0 : delta_q) | edge_vec;
    end
  end

  assign irq = ier_q[MSI_EN_BIT] & (|delta_q);

  always_comb begin
    case (bus_addr)
      A_IER:   bus_rdata = {4'b0, ier_q};
      A_MCR:   bus_rdata = {3'b0, mcr_q};
      A_MSR:   bus_rdata = {state_q, delta_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_msr |=> ((delta_q & $past(delta_q)) == $past(delta_q))); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && edge_vec == 4'b0) |=> (delta_q == 4'b0)); // R4
  AST_RING_NO_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !state_q[2] |=> !$rose(delta_q[2])); // R5
  AST_LOOP_IGNORES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_q[4] && $past(mcr_q[4]) && $stable(mcr_q)) |=> $stable(state_q)); // R6
  AST_MCR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_MCR) |-> (bus_rdata[7:5] == 3'b0)); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (delta_q != 4'b0)); // R8
endmodule

// File: tb/modem_status_ctl_tb.sv
module modem_status_ctl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic cts_in = 0, dsr_in = 0, ri_in = 0, dcd_in = 0;
  logic loop_active, irq;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #4 clk = ~clk;

  modem_status_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
    .loop_active(loop_active), .irq(irq));

  always begin
    @(negedge clk);
    #2;
    if (bus_sel && bus_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: addr %0d read %02h expected %02h", r, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic rd_check(input logic [1:0] a, input logic [7:0] e, input string r);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    exp_q.push_back(e);
    req_q.push_back(r);
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic chk_bit(input logic act, input logic e, input string r);
    #2;
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", r, act, e);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_check(0, 8'h00, "R1");
    rd_check(1, 8'h00, "R1");
    rd_check(2, 8'h00, "R1");
    chk_bit(irq, 1'b0, "R1 irq");
    wr(0, 8'hFF);
    rd_check(0, 8'h0F, "R7 ier");
    cts_in = 1; settle();
    chk_bit(irq, 1'b1, "R8 irq set");
    rd_check(2, 8'h11, "R2 R3 cts");
    rd_check(2, 8'h10, "R4 cleared");
    chk_bit(irq, 1'b0, "R8 irq clear");
    dsr_in = 1; dcd_in = 1; settle();
    rd_check(2, 8'hBA, "R3 dsr dcd");
    rd_check(2, 8'hB0, "R4");
    ri_in = 1; settle();
    rd_check(2, 8'hF0, "R5 ring lead ignored");
    ri_in = 0; settle();
    rd_check(2, 8'hB4, "R5 ring trail");
    rd_check(2, 8'hB0, "R4");
    cts_in = 0; settle();
    cts_in = 1; settle();
    rd_check(2, 8'hB1, "R3 sticky");
    wr(0, 8'h00);
    dsr_in = 0; settle();
    chk_bit(irq, 1'b0, "R8 gated");
    rd_check(2, 8'h92, "R3 dsr fall");
    rd_check(2, 8'h90, "R4");
    @(negedge clk); cts_in = 0;
    @(negedge clk);
    rd_check(2, 8'h90, "R4 read during change");
    rd_check(2, 8'h81, "R4 change kept");
    wr(0, 8'h08);
    wr(1, 8'h10);
    chk_bit(loop_active, 1'b1, "R6 loop flag");
    rd_check(1, 8'h10, "R6 mcr");
    chk_bit(irq, 1'b1, "R8 loop irq");
    rd_check(2, 8'h08, "R6 loop sources");
    rd_check(2, 8'h00, "R6");
    wr(1, 8'h12);
    rd_check(2, 8'h11, "R6 rts to cts");
    cts_in = 1; dsr_in = 1; ri_in = 1; dcd_in = 1; settle();
    rd_check(2, 8'h10, "R6 pins ignored");
    wr(1, 8'hFD);
    rd_check(1, 8'h1D, "R7 mcr top");
    rd_check(2, 8'hEB, "R6 mapping");
    rd_check(2, 8'hE0, "R4");
    wr(1, 8'h19);
    rd_check(2, 8'hA4, "R5 R6 out1 trail");
    wr(1, 8'h00);
    chk_bit(loop_active, 1'b0, "R9 loop off");
    rd_check(2, 8'hF1, "R9 external back");
    rd_check(1, 8'h00, "R9 mcr");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule